// File: doc/BRIEF.md
# Shared-Term Programmable AND-OR Array

This block is the two-level logic core of a field-configurable logic device. It has 38 array inputs, a programmable AND plane of 67 product terms and a programmable OR plane of 50 sum terms. Each input reaches every product term in both polarities. Product terms 0 to 63 form a common pool. Any of them can feed any number of sum terms, so one decoded condition is built once and reused by many functions. Product terms 64 to 66 bypass the OR plane and drive the global control bus directly.

The configuration is one long register. It is shifted in serially, most significant bit first, and then frozen by a load-done pulse. From that point every output is a pure combinational function of the data inputs, one AND level followed by one OR level. Sum terms 0 to 47 feed twelve downstream logic cells, four per cell. Sum terms 48 and 49, together with the three direct product terms, form the global control bus used for clocks and resets. Until the configuration is frozen, every output is held at zero.

Top module: `pla_shared_array`

## Requirements
- R1: AND-plane column 2*i carries input `data_in[i]` in true form and column 2*i+1 carries its complement, for i in 0..37.
- R2: A product term is the AND of its connected columns. A product term with no connected column evaluates to 1. A product term with both polarities of one input connected evaluates to 0.
- R3: A sum term is the OR of its connected product terms. A sum term with none connected evaluates to 0.
- R4: Each of product terms 0..63 can drive any set of the 50 sum terms at the same time (shared, not steered). OR-plane bit s*64+t connects product term t to sum term s.
- R5: `cell_sum[47:0]` carries sum terms 0..47. `glb_ctl[2:0]` carries product terms 64..66 directly. `glb_ctl[4:3]` carries sum terms 48..49.
- R6: The configuration vector is 8292 bits wide, with the OR plane in bits 3199..0 and the AND plane above it. Product term p uses bits 3200+76*p+col. While unlocked and `load_en` is high, one bit per clock is shifted in at bit 0, so the first bit sent ends in bit 8291.
- R7: A high `load_done` while unlocked freezes the configuration at the next clock edge. In that cycle no shift takes place.
- R8: From reset until the configuration is frozen, `cell_sum` and `glb_ctl` are zero, including while bits are being shifted.
- R9: Once frozen, `load_en`, `load_bit` and `load_done` have no effect until the next reset.
- R10: Once frozen, the outputs follow `data_in` combinationally through a single AND-OR level. A 16-bit equality comparator fits in 32 shared product terms.
- R11: Driving `rst_n` low clears the lock and zeroes the outputs without waiting for a clock edge. Its release reaches the logic through a two-stage synchronizer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for configuration loading |
| rst_n | input | 1 | Asynchronous active-low reset |
| load_en | input | 1 | Shift one configuration bit per clock while unlocked |
| load_bit | input | 1 | Serial configuration data, MSB first |
| load_done | input | 1 | Freeze the loaded configuration |
| data_in | input | 38 | Array inputs |
| cell_sum | output | 48 | Sum terms for the 12 logic cells, 4 each |
| glb_ctl | output | 5 | Global control: direct product terms [2:0], sum terms [4:3] |

## Verification
The main configuration builds a 16-bit equality comparator from 32 mismatch product terms. These terms are shared by a full-width sum, a low-byte sum and a duplicate sum.

The vectors are chosen to separate the functions:
- Equal words, including all zeros and all ones, show that the full-width and low-byte sums both stay low.
- A difference only in the high byte separates the full-width sum from the low-byte sum.
- A difference only in bit 0 shows one product term reaching three sums and a global sum at once.

The same configuration also holds the corner cases:
- an empty product term (reads 1)
- a self-contradicting product term (reads 0)
- an empty sum (reads 0)
- a complement-only term, which shows the polarity columns are not swapped

A second load builds a small shared-term function over three inputs and walks all eight input combinations. This shows that a reload after reset takes effect and that direct global product terms with no inputs connected read 1.

// File: rtl/pla_array_pkg.sv
package pla_array_pkg;

  localparam int IN_N          = 38;
  localparam int PT_N          = 67;
  localparam int GPT_N         = 3;
  localparam int CELL_N        = 12;
  localparam int ST_PER_CELL   = 4;
  localparam int GST_N         = 2;

  localparam int COL_N         = 2 * IN_N;
  localparam int SHR_PT_N      = PT_N - GPT_N;
  localparam int CELL_ST_N     = CELL_N * ST_PER_CELL;
  localparam int ST_N          = CELL_ST_N + GST_N;
  localparam int AND_W         = PT_N * COL_N;
  localparam int OR_W          = ST_N * SHR_PT_N;
  localparam int CFG_W         = AND_W + OR_W;
  localparam int GLB_W         = GPT_N + GST_N;
  localparam int SYNC_STAGES   = 2;

endpackage

// File: rtl/pla_rst_sync.sv
module pla_rst_sync #(
  parameter int STAGES = pla_array_pkg::SYNC_STAGES
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_sync_n = sync_q[STAGES-1];

endmodule

// File: rtl/pla_cfg_chain.sv
module pla_cfg_chain #(
  parameter int CFG_W = pla_array_pkg::CFG_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rst_sync_n,
  input  logic             load_en,
  input  logic             load_bit,
  input  logic             load_done,
  output logic [CFG_W-1:0] cfg,
  output logic             locked
);

  logic [CFG_W-1:0] cfg_q;
  logic [CFG_W-1:0] cfg_d;
  logic             shift_en;
  logic             locked_q;
  logic             locked_d;

  // next state: the freeze request wins over a shift in the same cycle
  always_comb begin
    shift_en = rst_sync_n && !locked_q && load_en && !load_done;
    cfg_d    = {cfg_q[CFG_W-2:0], load_bit};
    locked_d = locked_q || (rst_sync_n && load_done);
  end

  // configuration storage carries no reset; outputs are gated until locked
  always_ff @(posedge clk) begin
    if (shift_en) begin
      cfg_q <= cfg_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      locked_q <= 1'b0;
    end else begin
      locked_q <= locked_d;
    end
  end

  assign cfg    = cfg_q;
  assign locked = locked_q;

endmodule

// File: rtl/pla_and_plane.sv
module pla_and_plane #(
  parameter int IN_N = pla_array_pkg::IN_N,
  parameter int PT_N = pla_array_pkg::PT_N,
  localparam int COL_N = 2 * IN_N
) (
  input  logic [IN_N-1:0]       data_in,
  input  logic [PT_N*COL_N-1:0] and_cfg,
  output logic [PT_N-1:0]       pt
);

  logic [COL_N-1:0] lit;

  for (genvar gi = 0; gi < IN_N; gi++) begin : g_lit
    assign lit[2*gi]   = data_in[gi];
    assign lit[2*gi+1] = ~data_in[gi];
  end

  // an unconnected column is forced to 1 so it cannot pull the term low
  for (genvar gp = 0; gp < PT_N; gp++) begin : g_pt
    assign pt[gp] = &(lit | ~and_cfg[gp*COL_N +: COL_N]);
  end

endmodule

// File: rtl/pla_or_plane.sv
module pla_or_plane #(
  parameter int SHR_PT_N = pla_array_pkg::SHR_PT_N,
  parameter int ST_N     = pla_array_pkg::ST_N
) (
  input  logic [SHR_PT_N-1:0]      pt_shared,
  input  logic [ST_N*SHR_PT_N-1:0] or_cfg,
  output logic [ST_N-1:0]          sum
);

  for (genvar gs = 0; gs < ST_N; gs++) begin : g_sum
    assign sum[gs] = |(pt_shared & or_cfg[gs*SHR_PT_N +: SHR_PT_N]);
  end

endmodule

// File: rtl/pla_shared_array.sv
module pla_shared_array #(
  parameter int IN_N        = pla_array_pkg::IN_N,
  parameter int PT_N        = pla_array_pkg::PT_N,
  parameter int GPT_N       = pla_array_pkg::GPT_N,
  parameter int CELL_N      = pla_array_pkg::CELL_N,
  parameter int ST_PER_CELL = pla_array_pkg::ST_PER_CELL,
  parameter int GST_N       = pla_array_pkg::GST_N,
  parameter int SYNC_STAGES = pla_array_pkg::SYNC_STAGES,
  localparam int COL_N      = 2 * IN_N,
  localparam int SHR_PT_N   = PT_N - GPT_N,
  localparam int CELL_ST_N  = CELL_N * ST_PER_CELL,
  localparam int ST_N       = CELL_ST_N + GST_N,
  localparam int AND_W      = PT_N * COL_N,
  localparam int OR_W       = ST_N * SHR_PT_N,
  localparam int CFG_W      = AND_W + OR_W,
  localparam int GLB_W      = GPT_N + GST_N
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 load_en,
  input  logic                 load_bit,
  input  logic                 load_done,
  input  logic [IN_N-1:0]      data_in,
  output logic [CELL_ST_N-1:0] cell_sum,
  output logic [GLB_W-1:0]     glb_ctl
);

  logic             rst_loc_n;
  logic [CFG_W-1:0] cfg_w;
  logic             locked_w;
  logic [PT_N-1:0]  pt_w;
  logic [ST_N-1:0]  sum_w;
  logic [GLB_W-1:0] glb_raw;

  pla_rst_sync #(
    .STAGES (SYNC_STAGES)
  ) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_loc_n)
  );

  pla_cfg_chain #(
    .CFG_W (CFG_W)
  ) u_cfg (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_loc_n),
    .load_en    (load_en),
    .load_bit   (load_bit),
    .load_done  (load_done),
    .cfg        (cfg_w),
    .locked     (locked_w)
  );

  pla_and_plane #(
    .IN_N (IN_N),
    .PT_N (PT_N)
  ) u_and (
    .data_in (data_in),
    .and_cfg (cfg_w[CFG_W-1:OR_W]),
    .pt      (pt_w)
  );

  pla_or_plane #(
    .SHR_PT_N (SHR_PT_N),
    .ST_N     (ST_N)
  ) u_or (
    .pt_shared (pt_w[SHR_PT_N-1:0]),
    .or_cfg    (cfg_w[OR_W-1:0]),
    .sum       (sum_w)
  );

  assign glb_raw = {sum_w[ST_N-1:CELL_ST_N], pt_w[PT_N-1:SHR_PT_N]};

  always_comb begin
    cell_sum = locked_w ? sum_w[CELL_ST_N-1:0] : '0;
    glb_ctl  = locked_w ? glb_raw : '0;
  end

endmodule

// File: rtl/pla_shared_array_chk.sv
module pla_shared_array_chk #(
  parameter int IN_N      = pla_array_pkg::IN_N,
  parameter int CFG_W     = pla_array_pkg::CFG_W,
  parameter int CELL_ST_N = pla_array_pkg::CELL_ST_N,
  parameter int GLB_W     = pla_array_pkg::GLB_W
) (
  input logic                 clk,
  input logic                 rst_sync_n,
  input logic                 load_en,
  input logic                 load_bit,
  input logic                 load_done,
  input logic [IN_N-1:0]      data_in,
  input logic [CELL_ST_N-1:0] cell_sum,
  input logic [GLB_W-1:0]     glb_ctl,
  input logic [CFG_W-1:0]     cfg,
  input logic                 locked
);

  logic seen_done_q;

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      seen_done_q <= 1'b0;
    end else if (load_done) begin
      seen_done_q <= 1'b1;
    end
  end

  assert_zero_before_freeze_R8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !seen_done_q |-> (cell_sum == '0 && glb_ctl == '0));

  assert_freeze_on_done_R7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (load_done && !locked) |=> (locked && $stable(cfg)));

  assert_msb_first_shift_R6: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (load_en && !load_done && !locked) |=>
      (cfg[0] == $past(load_bit) && cfg[CFG_W-1:1] == $past(cfg[CFG_W-2:0])));

  assert_frozen_cfg_R9: assert property (@(posedge clk) disable iff (!rst_sync_n)
    locked |=> (locked && $stable(cfg)));

  assert_combinational_hold_R10: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (seen_done_q && $past(seen_done_q) && $stable(data_in)) |->
      ($stable(cell_sum) && $stable(glb_ctl)));

endmodule

bind pla_shared_array pla_shared_array_chk #(
  .IN_N      (IN_N),
  .CFG_W     (CFG_W),
  .CELL_ST_N (CELL_ST_N),
  .GLB_W     (GLB_W)
) u_chk (
  .clk        (clk),
  .rst_sync_n (rst_loc_n),
  .load_en    (load_en),
  .load_bit   (load_bit),
  .load_done  (load_done),
  .data_in    (data_in),
  .cell_sum   (cell_sum),
  .glb_ctl    (glb_ctl),
  .cfg        (cfg_w),
  .locked     (locked_w)
);

// File: tb/pla_shared_array_bench.sv
module pla_shared_array_bench;
  import pla_array_pkg::*;

  logic             clk;
  logic             rst_n;
  logic             load_en;
  logic             load_bit;
  logic             load_done;
  logic [IN_N-1:0]  data_in;
  logic [CELL_ST_N-1:0] cell_sum;
  logic [GLB_W-1:0] glb_ctl;

  logic [CFG_W-1:0] cfgv;
  int checks;
  int errors;

  pla_shared_array u_pla_shared_array (
    .clk       (clk),
    .rst_n     (rst_n),
    .load_en   (load_en),
    .load_bit  (load_bit),
    .load_done (load_done),
    .data_in   (data_in),
    .cell_sum  (cell_sum),
    .glb_ctl   (glb_ctl)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  // row = {x[37:32], b[15:0], a[15:0], exp {s47,s1,s0}, exp glb[4:0]}
  localparam logic [45:0] VECS [0:7] = '{
    {6'b000000, 16'h0000, 16'h0000, 3'b000, 5'b00010},
    {6'b000011, 16'h1234, 16'h1234, 3'b000, 5'b00011},
    {6'b000000, 16'h0000, 16'h0100, 3'b101, 5'b00010},
    {6'b000000, 16'h0000, 16'h0001, 3'b111, 5'b10010},
    {6'b001000, 16'h8000, 16'h0000, 3'b101, 5'b11010},
    {6'b000001, 16'hFFFF, 16'hFFFF, 3'b000, 5'b00010},
    {6'b000000, 16'hA5A4, 16'hA5A5, 3'b111, 5'b10010},
    {6'b111111, 16'h5A5A, 16'h5A5A, 3'b000, 5'b11011}
  };

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic set_lit(input int p, input int col);
    cfgv[OR_W + p*COL_N + col] = 1'b1;
  endtask

  task automatic set_or(input int s, input int p);
    cfgv[s*SHR_PT_N + p] = 1'b1;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  // shifts cfgv MSB first, then freezes it
  task automatic load_cfg(input bit probe);
    for (int k = CFG_W - 1; k >= 0; k--) begin
      @(negedge clk);
      load_en  = 1'b1;
      load_bit = cfgv[k];
      if (probe && k == CFG_W / 2) begin
        data_in = '1;
        #1;
        check(cell_sum == '0 && glb_ctl == '0, "R8 outputs zero while shifting",
              {11'd0, glb_ctl, cell_sum}, 64'd0);
      end
    end
    @(negedge clk);
    load_en   = 1'b0;
    load_done = 1'b1;
    @(negedge clk);
    load_done = 1'b0;
  endtask

  function automatic logic [CELL_ST_N-1:0] exp_cell_a(input logic [45:0] row);
    logic [CELL_ST_N-1:0] e;
    e     = '0;
    e[0]  = row[5];
    e[1]  = row[6];
    e[47] = row[7];
    e[5]  = 1'b1;
    e[8]  = ~row[45];
    return e;
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL R10 watchdog actual=running expected=finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [CELL_ST_N-1:0] held_cell;
    logic [GLB_W-1:0]     held_glb;
    checks    = 0;
    errors    = 0;
    rst_n     = 1'b0;
    load_en   = 1'b0;
    load_bit  = 1'b0;
    load_done = 1'b0;
    data_in   = '0;
    do_reset();

    // R8: reset state, outputs zero before any configuration
    data_in = '1;
    #1;
    check(cell_sum == '0 && glb_ctl == '0, "R8 reset state", {11'd0, glb_ctl, cell_sum}, 64'd0);

    // configuration A: 16-bit comparator plus corner terms
    cfgv = '0;
    for (int k = 0; k < 16; k++) begin
      set_lit(2*k,   2*k);            // R1 a_k true
      set_lit(2*k,   2*(16+k) + 1);   // R1 b_k complement
      set_lit(2*k+1, 2*k + 1);
      set_lit(2*k+1, 2*(16+k));
    end
    set_lit(32, 2*35);
    set_lit(41, 0);
    set_lit(41, 1);                   // R2 contradiction
    set_lit(42, 2*37 + 1);            // R1 complement-only term
    set_lit(64, 2*32);
    set_lit(64, 2*33);
    set_lit(66, 2*34);
    set_lit(66, 2*34 + 1);
    for (int t = 0; t < 32; t++) begin
      set_or(0, t);
      set_or(47, t);                  // R4 same terms shared by a second sum
    end
    for (int t = 0; t < 16; t++) set_or(1, t);
    set_or(5, 40);                    // R2 empty term reads 1
    set_or(6, 41);
    set_or(8, 42);
    set_or(48, 32);
    set_or(49, 0);
    set_or(49, 32);
    load_cfg(1'b1);

    // R6: first vector after an MSB-first load
    @(negedge clk);
    data_in = VECS[0][45:8];
    #1;
    check(cell_sum == exp_cell_a(VECS[0]), "R6 loaded function",
          {16'd0, cell_sum}, {16'd0, exp_cell_a(VECS[0])});

    // R10 R4 R5 R3 R2 R1: table walk
    for (int r = 0; r < 8; r++) begin
      @(negedge clk);
      data_in = VECS[r][45:8];
      #1;
      check(cell_sum == exp_cell_a(VECS[r]), "R10/R4/R3 cell sums",
            {16'd0, cell_sum}, {16'd0, exp_cell_a(VECS[r])});
      check(glb_ctl == VECS[r][4:0], "R5 global bus",
            {59'd0, glb_ctl}, {59'd0, VECS[r][4:0]});
    end

    // R9: loading attempts after freeze are ignored
    @(negedge clk);
    data_in = VECS[3][45:8];
    #1;
    held_cell = cell_sum;
    held_glb  = glb_ctl;
    for (int k = 0; k < 300; k++) begin
      @(negedge clk);
      load_en   = 1'b1;
      load_bit  = k[0];
      load_done = (k == 150);
    end
    @(negedge clk);
    load_en   = 1'b0;
    load_done = 1'b0;
    #1;
    check(cell_sum == held_cell && glb_ctl == held_glb, "R9 frozen after load attempts",
          {11'd0, glb_ctl, cell_sum}, {11'd0, held_glb, held_cell});
    @(negedge clk);
    data_in = VECS[7][45:8];
    #1;
    check(cell_sum == exp_cell_a(VECS[7]) && glb_ctl == VECS[7][4:0], "R9 function intact",
          {11'd0, glb_ctl, cell_sum}, {11'd0, VECS[7][4:0], exp_cell_a(VECS[7])});

    // R11: asynchronous reset assertion clears outputs without a clock edge
    @(negedge clk);
    #1;
    rst_n = 1'b0;
    #0.5;
    check(cell_sum == '0 && glb_ctl == '0, "R11 async clear",
          {11'd0, glb_ctl, cell_sum}, 64'd0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    #1;
    check(cell_sum == '0 && glb_ctl == '0, "R8 zero after reset release",
          {11'd0, glb_ctl, cell_sum}, 64'd0);

    // configuration B: shared term over three inputs, empty global terms
    cfgv = '0;
    set_lit(3, 0);
    set_lit(3, 2);
    set_lit(4, 5);
    set_or(10, 3);
    set_or(11, 3);
    set_or(11, 4);
    set_or(12, 4);
    load_cfg(1'b0);
    for (int v = 0; v < 8; v++) begin
      logic [CELL_ST_N-1:0] e;
      @(negedge clk);
      data_in = {35'h5_5555_5555, v[2:0]};
      #1;
      e     = '0;
      e[10] = v[0] & v[1];
      e[11] = (v[0] & v[1]) | ~v[2];
      e[12] = ~v[2];
      check(cell_sum == e, "R4/R3 reload shared term",
            {16'd0, cell_sum}, {16'd0, e});
      check(glb_ctl == 5'b00111, "R2/R5 empty direct terms",
            {59'd0, glb_ctl}, 64'h7);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule